// File: doc/BRIEF.md
# Weighted Pseudo-Random Test Bit Generator

This block supplies stimulus bits for on-chip self-test whose chance of being 1 is set per bit rather than fixed at one half. Some faults are hard to reach with even odds. One example is an output stuck at 0 on a wide AND gate, which only shows up when every input is 1. An even-odds source hits that case only once in sixteen patterns for a four-input gate.

A maximal-length 8-stage shift register with linear feedback advances once per enabled clock. Its stages give bits that are 1 with probability one half.

Each output bit owns a short AND chain fed from four distinct shift-register stages. The chain yields levels with probability 1/2, 1/4, 1/8 and 1/16. A 2-bit select picks one of these levels, and an invert control can then complement it, which gives 1 - p. The reachable weights are therefore 1/2, 1/4, 3/4, 1/8, 7/8, 1/16 and 15/16. All output bits are registered and are updated together on the same step enable. A seed port reloads the shift register, and a zero seed is replaced by a legal nonzero value.

Top module: `weighted_pattern_gen`

## Requirements
- R1: After reset the shift-register state is 8'h01 and `pattern` is all zeros.
- R2: On a step (`step_en`=1, `seed_load`=0) the state s becomes {s[6:0], s[7]^s[5]^s[4]^s[3]}, which is the feedback polynomial x^8+x^6+x^5+x^4+1. The state is never zero and repeats every 255 steps.
- R3: When `seed_load`=1 the next state is `seed`, or 8'h01 if `seed` is zero. A load takes priority over a step.
- R4: With `step_en`=0 and `seed_load`=0 the state and `pattern` keep their values, whatever `weight_sel` and `invert` do.
- R5: Output bit i draws its four chain inputs t0..t3 from state stages (2i+k) mod 8, for k=0..3. No stage is shared within one output bit.
- R6: The weight select for output i is `weight_sel[2i+1:2i]`. Code 0 gives t0, code 1 gives t0&t1, code 2 gives t0&t1&t2, and code 3 gives t0&t1&t2&t3.
- R7: When `invert[i]`=1, output i is the complement of the selected level. When `invert[i]`=0 the level passes unchanged.
- R8: `pattern` is updated only on a step. The new value is computed from the state before that step's shift. A cycle with `seed_load`=1 leaves `pattern` unchanged, even when `step_en` is also 1.
- R9: Over 255 consecutive steps the number of ones on an output is exact. It is 128, 64, 32 and 16 for codes 0..3 with invert 0. It is 239 for code 3 with invert 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Advance the shift register and update the outputs |
| seed_load | input | 1 | Load `seed` into the shift register |
| seed | input | 8 | Seed value; zero is replaced by 8'h01 |
| weight_sel | input | 8 | Two bits per output choosing the AND depth |
| invert | input | 4 | Per-output complement control |
| pattern | output | 4 | Registered weighted test bits |

## Verification
A step produces its `pattern` value at the clock edge where the step is sampled. That value depends on the state from before the edge. A seed load changes only the state, so a seed becomes visible in `pattern` at the edge of the next step, two edges after the load is applied.

The bench drives its inputs on falling edges and advances its behavioural model at the rising edge, taking care of this one-edge offset. It compares every output bit at the following falling edge, so a value that is early or late shows up as a mismatch. Full-period ones counts confirm the weights without relying on the model's stepping.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    localparam int LFSR_W = 8;
    // feedback taps for x^8+x^6+x^5+x^4+1 on a left-shifting register
    localparam logic [LFSR_W-1:0] FB_MASK = 8'hB8;
    localparam logic [LFSR_W-1:0] ZERO_SUB = 8'h01;
    localparam int LEVELS = 4;
    localparam int SEL_W = $clog2(LEVELS);

    typedef struct packed {
        logic [LFSR_W-1:0] state;
    } lfsr_st_t;
endpackage

// File: rtl/wpg_lfsr.sv
module wpg_lfsr
    import wpg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              load,
    input  logic [LFSR_W-1:0] seed,
    output logic [LFSR_W-1:0] state
);
    lfsr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.state = (seed == '0) ? ZERO_SUB : seed;
        end else if (adv) begin
            st_d.state = {st_q.state[LFSR_W-2:0], ^(st_q.state & FB_MASK)};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ZERO_SUB;
        end else begin
            st_q <= st_d;
        end
    end

    assign state = st_q.state;

    p_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state != '0);

    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load) |=> state[LFSR_W-1:1] == $past(state[LFSR_W-2:0]));

    p_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed != '0) |=> state == $past(seed));

    p_zero_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (load && seed == '0) |=> state == ZERO_SUB);
endmodule

// File: rtl/wpg_cell.sv
module wpg_cell
    import wpg_pkg::*;
#(
    parameter int BASE = 0
) (
    input  logic [LFSR_W-1:0] state,
    input  logic [SEL_W-1:0]  sel,
    input  logic              inv,
    output logic              y
);
    logic [LEVELS-1:0] taps;
    logic [LEVELS-1:0] chain;

    for (genvar k = 0; k < LEVELS; k++) begin : g_tap
        assign taps[k] = state[(BASE + k) % LFSR_W];
        if (k == 0) begin : g_first
            assign chain[k] = taps[k];
        end else begin : g_and
            assign chain[k] = chain[k-1] & taps[k];
        end
    end

    assign y = chain[sel] ^ inv;
endmodule

// File: rtl/weighted_pattern_gen.sv
module weighted_pattern_gen
    import wpg_pkg::*;
#(
    parameter int NUM_OUT = 4,
    parameter int STRIDE  = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_en,
    input  logic                      seed_load,
    input  logic [LFSR_W-1:0]         seed,
    input  logic [NUM_OUT*SEL_W-1:0]  weight_sel,
    input  logic [NUM_OUT-1:0]        invert,
    output logic [NUM_OUT-1:0]        pattern
);
    typedef struct packed {
        logic [NUM_OUT-1:0] bits;
    } out_st_t;

    logic [LFSR_W-1:0]  lfsr_state;
    logic [NUM_OUT-1:0] raw;
    out_st_t            out_d, out_q;

    wpg_lfsr i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (step_en),
        .load  (seed_load),
        .seed  (seed),
        .state (lfsr_state)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_bit
        wpg_cell #(.BASE((STRIDE * i) % LFSR_W)) i_cell (
            .state (lfsr_state),
            .sel   (weight_sel[i*SEL_W +: SEL_W]),
            .inv   (invert[i]),
            .y     (raw[i])
        );

        // a 1/16 level with no inversion can only be 1 if its first tap was 1
        p_full_weight_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (step_en && !seed_load && weight_sel[i*SEL_W +: SEL_W] == SEL_W'(LEVELS-1) && !invert[i])
            |=> (!pattern[i] || $past(lfsr_state[(STRIDE * i) % LFSR_W])));
    end

    always_comb begin
        out_d = out_q;
        if (step_en && !seed_load) begin
            out_d.bits = raw;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.bits <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pattern = out_q.bits;

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !seed_load) |=> $stable(pattern) && $stable(lfsr_state));

    p_load_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seed_load |=> $stable(pattern));
endmodule

// File: tb/test_weighted_pattern_gen.sv
module test_weighted_pattern_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NO = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_en = 1'b0;
    logic       seed_load = 1'b0;
    logic [7:0] seed = 8'h00;
    logic [7:0] weight_sel = 8'h00;
    logic [3:0] invert = 4'h0;
    logic [3:0] pattern;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_state;
    logic [3:0] m_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    weighted_pattern_gen i_weighted_pattern_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_en    (step_en),
        .seed_load  (seed_load),
        .seed       (seed),
        .weight_sel (weight_sel),
        .invert     (invert),
        .pattern    (pattern)
    );

    function automatic logic [7:0] m_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    function automatic logic m_weight(input logic [7:0] s, input int idx,
                                      input logic [1:0] sel, input logic inv);
        logic v = 1'b1;
        for (int k = 0; k <= int'(sel); k++) begin
            v = v & s[(2 * idx + k) % 8];
        end
        return v ^ inv;
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: pattern actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one clock: model follows the rising edge, comparison at the falling edge
    task automatic cyc(input string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_state = 8'h01;
            m_out = 4'h0;
        end else if (seed_load) begin
            m_state = (seed == 8'h00) ? 8'h01 : seed;
        end else if (step_en) begin
            for (int i = 0; i < NO; i++) begin
                m_out[i] = m_weight(m_state, i, weight_sel[2*i +: 2], invert[i]);
            end
            m_state = m_step(m_state);
        end
        @(negedge clk);
        check(tag, pattern, m_out);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int ones [4];
        logic [7:0] s;
        int per;

        m_state = 8'h01;
        m_out = 4'h0;
        repeat (3) cyc("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset value", pattern, 4'h0);

        // first step after reset: state 01, output 0 stage 0 is 1 (R5, R6)
        step_en = 1'b1;
        cyc("R1 R5 first step");
        check("R5 first step literal", pattern, 4'b0001);

        // mixed weights and inversions (R2, R5, R6, R7)
        for (int n = 0; n < 300; n++) begin
            weight_sel = 8'($urandom);
            invert = 4'($urandom);
            cyc("R2 R6 R7 random weights");
        end

        // R7: complement of same selection on all outputs
        weight_sel = 8'hFF;
        invert = 4'hF;
        repeat (20) cyc("R7 invert 15/16");

        // R4: idle, selects change, outputs hold
        step_en = 1'b0;
        for (int n = 0; n < 6; n++) begin
            weight_sel = 8'($urandom);
            invert = 4'($urandom);
            cyc("R4 hold");
        end

        // R3: zero seed replaced by 01
        seed_load = 1'b1;
        seed = 8'h00;
        cyc("R3 R8 zero seed load");
        seed_load = 1'b0;
        step_en = 1'b1;
        weight_sel = 8'h00;
        invert = 4'h0;
        cyc("R3 zero seed result");
        check("R3 zero seed literal", pattern, 4'b0001);

        // R3/R8: load with step both high, load wins and pattern holds
        seed_load = 1'b1;
        seed = 8'hFF;
        cyc("R8 load over step");
        seed_load = 1'b0;
        weight_sel = 8'hFF;
        cyc("R3 seed FF all ones");
        check("R3 seed FF literal", pattern, 4'hF);
        repeat (30) cyc("R2 after seed");

        // R9: full-period ones counts
        seed_load = 1'b1;
        seed = 8'h5A;
        cyc("R3 seed 5A");
        seed_load = 1'b0;
        weight_sel = {2'd3, 2'd2, 2'd1, 2'd0};
        invert = 4'h0;
        for (int i = 0; i < NO; i++) ones[i] = 0;
        for (int n = 0; n < 255; n++) begin
            cyc("R9 count run");
            for (int i = 0; i < NO; i++) ones[i] += int'(pattern[i]);
        end
        check_int("R9 ones code0", ones[0], 128);
        check_int("R9 ones code1", ones[1], 64);
        check_int("R9 ones code2", ones[2], 32);
        check_int("R9 ones code3", ones[3], 16);

        weight_sel = 8'hFF;
        invert = 4'hF;
        for (int i = 0; i < NO; i++) ones[i] = 0;
        for (int n = 0; n < 255; n++) begin
            cyc("R9 count run inverted");
            for (int i = 0; i < NO; i++) ones[i] += int'(pattern[i]);
        end
        for (int i = 0; i < NO; i++) check_int("R9 ones 15/16", ones[i], 239);

        // R2: period of the feedback sequence from the requirement itself
        s = 8'h01;
        per = 0;
        for (int n = 0; n < 300; n++) begin
            s = m_step(s);
            per++;
            if (s == 8'h01) break;
        end
        check_int("R2 period", per, 255);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule